// File: doc/BRIEF.md
# 3x3 Pixel Convolution Engine

This block is a synchronous image-filter datapath. Three 8-bit pixel rows arrive in parallel, one pixel per row on each clock. Each row passes through a three-deep shift register, so the nine registers form a 3x3 window. Every window position is multiplied by its own stored signed 8-bit coefficient. The nine products are summed into a 20-bit two's-complement result. The surrounding logic supplies the three rows already aligned, so no line buffering happens inside the block.

The same nine coefficients also serve a one-dimensional mode. In that mode the three row shift registers are chained into a single nine-sample delay line, fed only from the first pixel bus, and the block acts as a 9-tap FIR filter.

Configuration uses a narrow write port with an 8-bit data bus, a 3-bit address and a load strobe. The strobe is synchronized into the clock domain. Each coefficient row is loaded by shifting values in. A separate mode register selects 2D or FIR operation. An active-low frame input clears the datapath between frames but keeps the configuration. A hold input freezes the datapath.

Top module: `conv3_engine`

## Requirements
- R1: In 2D mode the result equals the sum over all nine window positions of pixel times coefficient. Pixels are unsigned 8-bit values, coefficients are two's-complement 8-bit values, and the result is a 20-bit two's-complement value.
- R2: A pixel captured at an active clock edge k first affects the result that is visible after active edge k+2.
- R3: In 2D mode, window position (row r, column j) holds the sample that entered on pixel bus r exactly j active edges earlier. Bus `pix_a` is row 0, `pix_b` is row 1 and `pix_c` is row 2.
- R4: When the mode bit is 1 (FIR mode), tap t = 3r + j holds the sample that entered on `pix_a` t active edges earlier. In this mode `pix_b` and `pix_c` have no effect on the result.
- R5: A write is taken at the third rising clock edge after `cfg_ld` rises. Address and data must stay stable until that edge.
  - Writing to address r (0, 1 or 2) shifts coefficient row r: column 1 moves to column 2, column 0 moves to column 1, and the data goes into column 0. Position (r, j) multiplies window position (r, j).
- R6: Writing to address 7 sets the mode bit from data bit 0: 0 selects 2D and 1 selects FIR. Writes to addresses 3 to 6 change nothing.
- R7: While `frame_n` is low, the result and all pipeline state read zero. Normal operation resumes on the third rising edge after `frame_n` rises. Coefficients and the mode bit survive the frame reset.
- R8: When `hold` is high at a rising edge, the next rising edge changes no datapath register. This stretches the latency of R2 by the number of held edges. Configuration writes still complete during hold.
- R9: The result never overflows. Full-scale inputs give exactly -293760 (all coefficients -128) or 291465 (all coefficients 127).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state |
| frame_n | input | 1 | Asynchronous active-low frame reset of the datapath |
| hold | input | 1 | Registered freeze request |
| pix_a | input | 8 | Pixel row 0; the only sample input in FIR mode |
| pix_b | input | 8 | Pixel row 1 |
| pix_c | input | 8 | Pixel row 2 |
| cfg_data | input | 8 | Configuration write data |
| cfg_addr | input | 3 | Configuration register address |
| cfg_ld | input | 1 | Load strobe; its rising edge requests a write |
| result | output | 20 | Two's-complement convolution result |

## Verification
The bench goes after the following corner cases:

- Exact two-edge latency. A single-pixel impulse after a flushed window exposes a pipeline that is one stage short or long, because the coefficient shows up on the wrong edge.
- Coefficient shift order. Distinct coefficients combined with impulses on each row expose a reversed shift order or a wrong row decode, because the impulse response comes out permuted.
- FIR chaining. Garbage on `pix_b` and `pix_c` while in FIR mode catches a design that does not chain the rows, because that garbage reaches the result.
- Full-scale sign extension. Full-scale pixels with coefficients of -128 and 127 catch a design that treats the coefficients as unsigned or truncates the sum.
- Hold alignment. Random hold patterns catch a hold that acts at once instead of one edge late.
- Frame reset. A reset in the middle of a stream, followed by filtering without reloading, catches a frame reset that wipes the coefficients or the mode bit.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

  // Window edge length; the window holds WIN_N*WIN_N taps.
  localparam int WIN_N = 3;

  typedef enum logic {
    MODE_2D  = 1'b0,
    MODE_FIR = 1'b1
  } filt_mode_e;

endpackage

// File: rtl/conv3_ctrl.sv
// Reset release synchronizer and registered hold.
module conv3_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic frame_n,
  input  logic hold,
  output logic rst_n,
  output logic hold_q,
  output logic adv
);

  logic [SYNC_STAGES-1:0] rel_q;
  logic [SYNC_STAGES-1:0] rel_d;
  logic                   hold_d;

  always_comb begin
    rel_d = {rel_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge frame_n) begin
    if (!frame_n) begin
      rel_q <= '0;
    end else begin
      rel_q <= rel_d;
    end
  end

  assign rst_n = rel_q[SYNC_STAGES-1];

  always_comb begin
    hold_d = hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign adv = ~hold_q;

endmodule

// File: rtl/conv3_cfg.sv
// Strobe synchronizer, coefficient row shifters and mode register.
module conv3_cfg
  import conv3_pkg::*;
#(
  parameter int N           = 3,
  parameter int COEF_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [COEF_W-1:0]            data,
  output logic [N*N-1:0][COEF_W-1:0]   coef,
  output logic                         fir_mode,
  output logic                         wr_pulse
);

  localparam int TAPS      = N * N;
  localparam int MODE_ADDR = (1 << ADDR_W) - 1;

  logic [SYNC_STAGES:0]          ld_q;
  logic [SYNC_STAGES:0]          ld_d;
  logic [N-1:0]                  row_sel;
  logic                          mode_sel;
  logic [TAPS-1:0][COEF_W-1:0]   coef_d;
  filt_mode_e                    mode_q;

  // Synchronizer plus one extra stage for edge detection.
  always_comb begin
    ld_d = {ld_q[SYNC_STAGES-1:0], ld};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q <= '0;
    end else begin
      ld_q <= ld_d;
    end
  end

  assign wr_pulse = ld_q[SYNC_STAGES-1] & ~ld_q[SYNC_STAGES];
  assign mode_sel = wr_pulse && (addr == ADDR_W'(MODE_ADDR));

  genvar r, c;
  generate
    for (r = 0; r < N; r++) begin : g_row
      assign row_sel[r] = wr_pulse && (addr == ADDR_W'(r));
      for (c = 0; c < N; c++) begin : g_col
        if (c == 0) begin : g_head
          assign coef_d[r*N+c] = data;
        end else begin : g_tail
          assign coef_d[r*N+c] = coef[r*N+c-1];
        end
        // Configuration storage is deliberately outside the frame reset.
        always_ff @(posedge clk) begin
          if (row_sel[r]) begin
            coef[r*N+c] <= coef_d[r*N+c];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (mode_sel) begin
      mode_q <= filt_mode_e'(data[0]);
    end
  end

  assign fir_mode = (mode_q == MODE_FIR);

endmodule

// File: rtl/conv3_window.sv
// Three row shift registers; chained into one delay line in FIR mode.
module conv3_window #(
  parameter int N     = 3,
  parameter int PIX_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        fir_mode,
  input  logic [N-1:0][PIX_W-1:0]     pix_in,
  output logic [N*N-1:0][PIX_W-1:0]   win
);

  localparam int TAPS = N * N;

  logic [TAPS-1:0][PIX_W-1:0] win_d;

  genvar r, c;
  generate
    for (r = 0; r < N; r++) begin : g_row
      for (c = 0; c < N; c++) begin : g_col
        if (c == 0 && r == 0) begin : g_src
          assign win_d[0] = pix_in[0];
        end else if (c == 0) begin : g_link
          assign win_d[r*N] = fir_mode ? win[r*N-1] : pix_in[r];
        end else begin : g_shift
          assign win_d[r*N+c] = win[r*N+c-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else if (adv) begin
      win <= win_d;
    end
  end

endmodule

// File: rtl/conv3_mac.sv
// Registered products followed by a registered adder tree.
module conv3_mac #(
  parameter int N      = 3,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int RES_W  = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic [N*N-1:0][PIX_W-1:0]   win,
  input  logic [N*N-1:0][COEF_W-1:0]  coef,
  output logic [RES_W-1:0]            result
);

  localparam int TAPS   = N * N;
  localparam int PROD_W = PIX_W + COEF_W + 1;

  logic [TAPS-1:0][PROD_W-1:0] prod_d;
  logic [TAPS-1:0][PROD_W-1:0] prod_q;
  logic [RES_W-1:0]            sum_d;
  logic [RES_W-1:0]            sum_q;

  genvar t;
  generate
    for (t = 0; t < TAPS; t++) begin : g_mul
      logic signed [PROD_W-1:0] pix_ext;
      logic signed [PROD_W-1:0] coef_ext;
      assign pix_ext   = {{(PROD_W-PIX_W){1'b0}}, win[t]};
      assign coef_ext  = {{(PROD_W-COEF_W){coef[t][COEF_W-1]}}, coef[t]};
      assign prod_d[t] = pix_ext * coef_ext;
    end
  endgenerate

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < TAPS; i++) begin
      sum_d = sum_d + {{(RES_W-PROD_W){prod_q[i][PROD_W-1]}}, prod_q[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
    end else if (adv) begin
      prod_q <= prod_d;
      sum_q  <= sum_d;
    end
  end

  assign result = sum_q;

endmodule

// File: rtl/conv3_engine.sv
module conv3_engine #(
  parameter int PIX_W       = 8,
  parameter int COEF_W      = 8,
  parameter int RES_W       = 20,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              frame_n,
  input  logic              hold,
  input  logic [PIX_W-1:0]  pix_a,
  input  logic [PIX_W-1:0]  pix_b,
  input  logic [PIX_W-1:0]  pix_c,
  input  logic [COEF_W-1:0] cfg_data,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_ld,
  output logic [RES_W-1:0]  result
);

  localparam int N    = conv3_pkg::WIN_N;
  localparam int TAPS = N * N;

  logic                        rst_n;
  logic                        hold_q;
  logic                        adv;
  logic                        wr_pulse;
  logic                        fir_mode;
  logic [N-1:0][PIX_W-1:0]     pix_bus;
  logic [TAPS-1:0][PIX_W-1:0]  win;
  logic [TAPS-1:0][COEF_W-1:0] coef;

  assign pix_bus = {pix_c, pix_b, pix_a};

  conv3_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .frame_n(frame_n),
    .hold   (hold),
    .rst_n  (rst_n),
    .hold_q (hold_q),
    .adv    (adv)
  );

  conv3_cfg #(
    .N          (N),
    .COEF_W     (COEF_W),
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (cfg_ld),
    .addr    (cfg_addr),
    .data    (cfg_data),
    .coef    (coef),
    .fir_mode(fir_mode),
    .wr_pulse(wr_pulse)
  );

  conv3_window #(
    .N    (N),
    .PIX_W(PIX_W)
  ) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .fir_mode(fir_mode),
    .pix_in  (pix_bus),
    .win     (win)
  );

  conv3_mac #(
    .N     (N),
    .PIX_W (PIX_W),
    .COEF_W(COEF_W),
    .RES_W (RES_W)
  ) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .win   (win),
    .coef  (coef),
    .result(result)
  );

endmodule

// File: rtl/conv3_engine_chk.sv
module conv3_engine_chk #(
  parameter int N      = 3,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int RES_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             wr_pulse,
  input logic [RES_W-1:0] result
);

  localparam longint LIMIT = longint'(N * N) * ((longint'(1) << PIX_W) - 1)
                             * (longint'(1) << (COEF_W - 1));

  // R7: pipeline output reads zero while the internal reset is active
  p_reset_zero_r7: assert property (@(posedge clk)
    !rst_n |-> (result == '0));

  // R7: first sampled cycle out of reset still shows zero
  p_release_zero_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> (result == '0));

  // R8: a sampled hold freezes the result across the following edge
  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ##1 $stable(result));

  // R5: one write per strobe edge
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R9: the result stays inside the full-scale envelope
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'($signed(result)) <= LIMIT) && (longint'($signed(result)) >= -LIMIT));

endmodule

bind conv3_engine conv3_engine_chk #(
  .N     (conv3_pkg::WIN_N),
  .PIX_W (PIX_W),
  .COEF_W(COEF_W),
  .RES_W (RES_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hold    (hold),
  .wr_pulse(wr_pulse),
  .result  (result)
);

// File: tb/conv3_engine_tb.sv
module conv3_engine_tb;

  logic        clk = 1'b0;
  logic        frame_n;
  logic        hold;
  logic        cfg_ld;
  logic [7:0]  pix_a, pix_b, pix_c, cfg_data;
  logic [2:0]  cfg_addr;
  logic [19:0] result;

  always #10 clk = ~clk;

  conv3_engine u_dut (
    .clk     (clk),
    .frame_n (frame_n),
    .hold    (hold),
    .pix_a   (pix_a),
    .pix_b   (pix_b),
    .pix_c   (pix_c),
    .cfg_data(cfg_data),
    .cfg_addr(cfg_addr),
    .cfg_ld  (cfg_ld),
    .result  (result)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R7";
  bit    done     = 1'b0;

  // Bench model state derived from the requirements.
  int mw[9];
  int mc[9];
  int s1_m, res_m, rst_cnt;
  bit hq_m, fir_m, in_rst;

  task automatic chk(input bit ok, input int act, input int exp, input string tag);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dot();
    int acc = 0;
    for (int t = 0; t < 9; t++) acc += mw[t] * mc[t];
    return acc;
  endfunction

  function automatic int res_now();
    return int'($signed(result));
  endfunction

  // Called at a falling edge: drive, model the next rising edge, check after it.
  task automatic step(input int p0, input int p1, input int p2, input bit h);
    int  d;
    bit  en;
    pix_a = p0[7:0];
    pix_b = p1[7:0];
    pix_c = p2[7:0];
    hold  = h;
    if (!in_rst) begin
      if (rst_cnt > 0) begin
        rst_cnt--;
      end else begin
        en   = !hq_m;
        d    = dot();
        hq_m = h;
        if (en) begin
          res_m = s1_m;
          s1_m  = d;
          if (fir_m) begin
            for (int t = 8; t > 0; t--) mw[t] = mw[t-1];
            mw[0] = p0;
          end else begin
            for (int r = 0; r < 3; r++) begin
              mw[3*r+2] = mw[3*r+1];
              mw[3*r+1] = mw[3*r];
            end
            mw[0] = p0;
            mw[3] = p1;
            mw[6] = p2;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(res_now() == res_m, res_now(), res_m, cur_req);
  endtask

  task automatic cfg_write(input int a, input int d);
    int sd;
    cfg_addr = a[2:0];
    cfg_data = d[7:0];
    cfg_ld   = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1'b0);
    sd = (d[7:0] >= 128) ? (d[7:0] - 256) : d[7:0];
    if (a < 3) begin
      mc[3*a+2] = mc[3*a+1];
      mc[3*a+1] = mc[3*a];
      mc[3*a]   = sd;
    end else if (a == 7) begin
      fir_m = d[0];
    end
    cfg_ld = 1'b0;
    for (int i = 0; i < 2; i++) step(0, 0, 0, 1'b0);
  endtask

  task automatic load_coefs(input int c[9]);
    for (int r = 0; r < 3; r++)
      for (int j = 2; j >= 0; j--)
        cfg_write(r, c[3*r+j] & 255);
  endtask

  task automatic frame_pulse();
    frame_n = 1'b0;
    in_rst  = 1'b1;
    hold    = 1'b0;
    for (int t = 0; t < 9; t++) mw[t] = 0;
    s1_m  = 0;
    res_m = 0;
    hq_m  = 1'b0;
    #1;
    chk(res_now() == 0, res_now(), 0, "R7");
    step(7, 7, 7, 1'b0);
    step(7, 7, 7, 1'b0);
    frame_n = 1'b1;
    in_rst  = 1'b0;
    rst_cnt = 2;
  endtask

  initial begin
    int c[9];
    void'($urandom(32'h5eed_0c3a));
    frame_n = 1'b0; hold = 1'b0; cfg_ld = 1'b0;
    pix_a = '0; pix_b = '0; pix_c = '0;
    cfg_addr = '0; cfg_data = '0;
    in_rst = 1'b1; rst_cnt = 0; hq_m = 1'b0; fir_m = 1'b0;
    s1_m = 0; res_m = 0;
    for (int t = 0; t < 9; t++) begin mw[t] = 0; mc[t] = 0; end

    @(negedge clk);
    @(negedge clk);
    cur_req = "R7";
    chk(res_now() == 0, res_now(), 0, "R7 reset state");
    frame_n = 1'b1;
    in_rst  = 1'b0;
    rst_cnt = 2;

    // R5 and R6: mode to 2D, distinct coefficients, row impulses
    cur_req = "R6";
    cfg_write(7, 0);
    cur_req = "R5";
    c = '{1, 2, 3, -4, 5, -6, 7, 8, -9};
    load_coefs(c);
    step(0, 50, 0, 1'b0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1'b0);
    step(0, 0, 9, 1'b0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1'b0);

    // R2: exact latency of an impulse on row 0
    cur_req = "R2";
    step(10, 0, 0, 1'b0);
    step(0, 0, 0, 1'b0);
    chk(res_now() == 0, res_now(), 0, "R2 one edge after capture");
    step(0, 0, 0, 1'b0);
    chk(res_now() == 10, res_now(), 10, "R2 two edges after capture");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1'b0);

    // R1 and R3: random 2D stream
    cur_req = "R1";
    for (int i = 0; i < 60; i++)
      step($urandom_range(255), $urandom_range(255), $urandom_range(255), 1'b0);
    cur_req = "R3";
    for (int i = 0; i < 20; i++)
      step($urandom_range(255), $urandom_range(255), $urandom_range(255), 1'b0);

    // R6: unused addresses leave coefficients and mode untouched
    cur_req = "R6";
    for (int a = 3; a < 7; a++) cfg_write(a, 8'h81 + a);
    step(0, 50, 0, 1'b0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1'b0);
    for (int i = 0; i < 20; i++)
      step($urandom_range(255), $urandom_range(255), $urandom_range(255), 1'b0);

    // R9: full-scale envelopes
    cur_req = "R9";
    for (int t = 0; t < 9; t++) c[t] = -128;
    load_coefs(c);
    for (int i = 0; i < 5; i++) step(255, 255, 255, 1'b0);
    chk(res_now() == -293760, res_now(), -293760, "R9 negative full scale");
    for (int t = 0; t < 9; t++) c[t] = 127;
    load_coefs(c);
    for (int i = 0; i < 5; i++) step(255, 255, 255, 1'b0);
    chk(res_now() == 291465, res_now(), 291465, "R9 positive full scale");

    // R4: FIR mode with garbage on the other buses
    cur_req = "R4";
    for (int t = 0; t < 9; t++) c[t] = t + 1;
    load_coefs(c);
    cfg_write(7, 1);
    for (int i = 0; i < 12; i++) step(0, 200, 13, 1'b0);
    step(1, 200, 13, 1'b0);
    for (int i = 0; i < 12; i++) step(0, 99, 250, 1'b0);
    for (int t = 0; t < 9; t++) c[t] = int'($urandom_range(255)) - 128;
    load_coefs(c);
    for (int i = 0; i < 50; i++)
      step($urandom_range(255), $urandom_range(255), $urandom_range(255), 1'b0);

    // R8: random hold pattern in both modes
    cur_req = "R8";
    for (int i = 0; i < 60; i++)
      step($urandom_range(255), $urandom_range(255), $urandom_range(255),
           ($urandom_range(2) == 0));
    step(0, 0, 0, 1'b0);
    cfg_write(7, 0);
    for (int i = 0; i < 60; i++)
      step($urandom_range(255), $urandom_range(255), $urandom_range(255),
           ($urandom_range(2) == 0));
    step(0, 0, 0, 1'b0);

    // R7: frame reset mid-stream, then filter without reloading
    cur_req = "R7";
    frame_pulse();
    for (int i = 0; i < 30; i++)
      step($urandom_range(255), $urandom_range(255), $urandom_range(255), 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule